// File: doc/BRIEF.md
# Burst Page-Crossing Monitor

This block watches one address channel of a memory-mapped burst bus and judges every accepted request against the rule that an incrementing burst must stay inside one 4 KiB page. When valid and ready are both high, it takes the start address, the length field, the size code and the burst type. It works out the address of the last byte the burst really touches. The start is first rounded down to the beat size, so an unaligned first beat counts only the bytes up to the next size boundary. One cycle later it presents that address, a per-request violation flag and a pulse that marks the result as fresh.

A sticky error bit collects every violation seen since the last reset. Bursts of fixed and wrapping type are exempt. Bursts whose end would run past the top of the address space count as violations and do not wrap around. The monitor drives nothing back onto the bus. It is meant to sit beside an interconnect port or a master model as a synthesizable protocol guard.

Top module: `burst_page_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), `chk_valid_o`, `viol_o`, `sticky_err_o` and `last_addr_o` are all 0 after that edge, even if a handshake happens in the same cycle.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `chk_valid_o` is 1 in exactly the cycle after such a handshake. Without a handshake, `last_addr_o` keeps its previous value.
- R3: One cycle after a handshake, `last_addr_o` equals (start rounded down to a multiple of 2^size) + (len+1)·2^size − 1, taken modulo 2^ADDR_W. Bytes per beat are 2^size and beats are len+1, so len 0 is a single beat.
- R4: For an INCR request (`req_burst` = 2'b01), `viol_o` is 1 in the cycle after the handshake exactly when address bits [ADDR_W-1:12] of the start differ from those of the last byte.
- R5: An unaligned INCR start is judged by its true last byte. Start 0xFFF with len 0 and size 1 is legal, and so is start 0xFFE with len 0 and size 2.
- R6: An INCR burst whose last byte lies at or above 2^ADDR_W is a violation. The comparison is made one bit wider than the address.
- R7: Requests with burst code 2'b00 (fixed), 2'b10 (wrapping) or 2'b11 never raise `viol_o` and never set `sticky_err_o`.
- R8: `sticky_err_o` becomes 1 in the same cycle as any `viol_o` and then stays 1 until a reset.
- R9: `viol_o` is 0 in every cycle that does not follow a handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Address request valid |
| req_ready | input | 1 | Address request ready |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Length field (beats − 1) |
| req_size | input | SIZE_W | Size code, bytes per beat = 2^code |
| req_burst | input | 2 | Burst type: 00 fixed, 01 incr, 10 wrap |
| chk_valid_o | output | 1 | Result is fresh (cycle after handshake) |
| viol_o | output | 1 | Last judged request crossed a page |
| last_addr_o | output | ADDR_W | Last byte address of last judged request |
| sticky_err_o | output | 1 | Any violation since reset |

## Verification
Two events can meet on the same clock edge: an offending INCR handshake and the synchronous reset. The bench raises both in one cycle and then expects every output, including the sticky bit, to read 0. A second overlap arises when a violation arrives while the sticky bit is already set, or when a legal burst directly follows an illegal one. The bench runs such back-to-back requests with random addresses clustered near page ends, so the per-request flag has to drop while the sticky bit holds. Each result is compared with a 64-bit reference computed in the bench from the requirement formula.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/bpg_span_calc.sv
module bpg_span_calc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len_field,
  input  logic [SIZE_W-1:0] size_code,
  output logic [ADDR_W:0]   last_wide
);
  localparam int WW = ADDR_W + 1;

  function automatic logic [WW-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    return (WW'(1) << sz) - WW'(1);
  endfunction

  function automatic logic [WW-1:0] align_down(input logic [ADDR_W-1:0] a,
                                               input logic [SIZE_W-1:0] sz);
    return {1'b0, a} & ~size_mask(sz);
  endfunction

  function automatic logic [WW-1:0] span_bytes(input logic [LEN_W-1:0] ln,
                                               input logic [SIZE_W-1:0] sz);
    return (WW'(ln) + WW'(1)) << sz;
  endfunction

  always_comb begin
    last_wide = align_down(start_addr, size_code)
              + span_bytes(len_field, size_code) - WW'(1);
  end
endmodule

// File: rtl/bpg_page_cmp.sv
module bpg_page_cmp #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   last_wide,
  output logic              crosses
);
  localparam int PW = ADDR_W + 1 - PAGE_LOG2;

  function automatic logic [PW-1:0] page_of(input logic [ADDR_W:0] a);
    return a[ADDR_W:PAGE_LOG2];
  endfunction

  always_comb begin
    crosses = page_of(last_wide) != page_of({1'b0, start_addr});
  end
endmodule

// File: rtl/bpg_result_reg.sv
module bpg_result_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs,
  input  logic              is_incr,
  input  logic              crosses,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              chk_valid_q,
  output logic              viol_q,
  output logic [ADDR_W-1:0] last_q,
  output logic              sticky_q
);
  logic hit;
  assign hit = hs & is_incr & crosses;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_valid_q <= 1'b0;
      viol_q      <= 1'b0;
      last_q      <= '0;
      sticky_q    <= 1'b0;
    end else begin
      chk_valid_q <= hs;
      viol_q      <= hit;
      if (hs) last_q <= last_addr;
      if (hit) sticky_q <= 1'b1;
    end
  end

  AST_HS_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> chk_valid_q); // R2
  AST_NO_FLAG_WITHOUT_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> !viol_q); // R9
  AST_NONINCR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !is_incr) |=> !viol_q); // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q |=> sticky_q); // R8
  AST_FLAG_IMPLIES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> sticky_q); // R8
endmodule

// File: rtl/burst_page_guard.sv
module burst_page_guard
  import bpg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int PAGE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_burst,
  output logic              chk_valid_o,
  output logic              viol_o,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic              sticky_err_o
);
  logic              hs;
  logic              is_incr;
  logic [ADDR_W:0]   span_last;
  logic              page_cross;

  assign hs      = req_valid & req_ready;
  assign is_incr = (req_burst == BT_INCR);

  bpg_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_span (
    .start_addr (req_addr),
    .len_field  (req_len),
    .size_code  (req_size),
    .last_wide  (span_last)
  );

  bpg_page_cmp #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u_cmp (
    .start_addr (req_addr),
    .last_wide  (span_last),
    .crosses    (page_cross)
  );

  bpg_result_reg #(.ADDR_W(ADDR_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs          (hs),
    .is_incr     (is_incr),
    .crosses     (page_cross),
    .last_addr   (span_last[ADDR_W-1:0]),
    .chk_valid_q (chk_valid_o),
    .viol_q      (viol_o),
    .last_q      (last_addr_o),
    .sticky_q    (sticky_err_o)
  );

  AST_SPAN_COVERS_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (span_last >= {1'b0, req_addr})); // R3
  AST_OVERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && is_incr && span_last[ADDR_W]) |=> viol_o); // R6
endmodule

// File: tb/burst_page_guard_tb.sv
`timescale 1ns/1ps
module burst_page_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_burst = '0;
  logic        chk_valid_o, viol_o, sticky_err_o;
  logic [31:0] last_addr_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_sticky = 0;
  logic [31:0] prev_last = '0;

  always #2.5 clk = ~clk;

  burst_page_guard u_dut (.*);

  function automatic longint unsigned ref_end(input logic [31:0] a, input logic [7:0] l,
                                              input logic [2:0] s);
    longint unsigned bpb = 64'd1 << s;
    longint unsigned base = longint'(a) - (longint'(a) % bpb);
    return base + (longint'(l) + 1) * bpb - 1;
  endfunction

  function automatic bit ref_viol(input logic [31:0] a, input logic [7:0] l,
                                  input logic [2:0] s, input logic [1:0] b);
    if (b != 2'b01) return 1'b0;
    return (ref_end(a, l, s) / 4096) != (longint'(a) / 4096);
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                      input logic [1:0] b, input string tag);
    bit ev;
    longint unsigned el;
    req_valid = 1; req_ready = 1;
    req_addr = a; req_len = l; req_size = s; req_burst = b;
    @(negedge clk);
    req_valid = 0;
    ev = ref_viol(a, l, s, b);
    el = ref_end(a, l, s);
    exp_sticky |= ev;
    prev_last = el[31:0];
    chk({tag, " R2 pulse"}, chk_valid_o, 1);
    chk({tag, " R3 last"}, last_addr_o, el[31:0]);
    chk({tag, " flag"}, viol_o, ev);
    chk({tag, " R8 sticky"}, sticky_err_o, exp_sticky);
  endtask

  task automatic idle_offer(input logic [31:0] a);
    req_valid = 1; req_ready = 0;
    req_addr = a; req_len = 8'hFF; req_size = 3'd4; req_burst = 2'b01;
    @(negedge clk);
    req_valid = 0;
    chk("R2 no pulse without ready", chk_valid_o, 0);
    chk("R9 no flag without handshake", viol_o, 0);
    chk("R2 last held", last_addr_o, prev_last);
    chk("R8 sticky held", sticky_err_o, exp_sticky);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", chk_valid_o, 0);
    chk("R1 reset flag", viol_o, 0);
    chk("R1 reset sticky", sticky_err_o, 0);
    chk("R1 reset last", last_addr_o, 0);
    rst_n = 1;
    @(negedge clk);

    send(32'h0000_0FFF, 8'd0, 3'd1, 2'b01, "R5 0xFFF single 2B");
    send(32'h0000_0FFE, 8'd0, 3'd2, 2'b01, "R5 0xFFE single 4B");
    send(32'h0000_0FF0, 8'd1, 3'd3, 2'b01, "R4 ends on page edge");
    send(32'h0000_2FF8, 8'd0, 3'd0, 2'b00, "R7 fixed legal");
    send(32'h0000_0FF8, 8'd1, 3'd3, 2'b00, "R7 fixed crossing");
    send(32'h0000_0FF8, 8'd7, 3'd2, 2'b10, "R7 wrap crossing");
    send(32'h0000_0FF8, 8'd7, 3'd2, 2'b11, "R7 reserved crossing");
    chk("R7 sticky untouched", sticky_err_o, 0);
    send(32'h0000_0FF8, 8'd1, 3'd3, 2'b01, "R4 crosses by 8");
    send(32'h0000_1000, 8'd0, 3'd0, 2'b01, "R8 legal after violation");
    idle_offer(32'h0000_0FF0);
    send(32'hFFFF_FFF0, 8'd1, 3'd4, 2'b01, "R6 past top");
    send(32'hFFFF_FFFF, 8'd0, 3'd0, 2'b01, "R6 last byte of space");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [7:0] l;
      a = $urandom;
      if ($urandom % 2) a[11:0] = 12'hF00 | 12'($urandom % 256);
      l = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 16);
      if ($urandom % 6 == 0) idle_offer(a);
      else send(a, l, 3'($urandom % 5), 2'($urandom % 4), "R4 random");
    end

    // reset and an offending handshake in the same cycle
    rst_n = 0;
    req_valid = 1; req_ready = 1;
    req_addr = 32'h0000_0FFC; req_len = 8'd3; req_size = 3'd2; req_burst = 2'b01;
    @(negedge clk);
    req_valid = 0;
    rst_n = 1;
    exp_sticky = 0; prev_last = '0;
    chk("R1 mid reset pulse", chk_valid_o, 0);
    chk("R1 mid reset flag", viol_o, 0);
    chk("R1 mid reset sticky", sticky_err_o, 0);
    chk("R1 mid reset last", last_addr_o, 0);
    send(32'h0000_0FFF, 8'd0, 3'd1, 2'b01, "R5 after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule